// File: doc/BRIEF.md
# Conditional Short-Branch Program Counter Unit

This block holds the program counter of a small processor with 16-bit instructions and feeds the execute stage through a one-entry prefetch slot. Each cycle it presents a fetch address and captures the returned word into the slot. The word in the slot is the instruction being executed, and `pc_o` gives its address. An external decoder turns that word into opcode, format, destination, a 4-bit immediate and a condition code. The block uses these fields, together with the zero and carry flags, to decide whether the program counter is redirected.

Two instructions can redirect. The first is a short-format add whose destination is the PC register. Its 4-bit immediate becomes an offset of +1..+8 or -8..-1, so no code means zero and a conditional branch cannot spin on its own address. The offset is added to the address of the branch itself. The second is a set of the PC to a full-width value. Both are conditional.

A taken redirect drops the word fetched in the same cycle. Fetching restarts at the target, which costs one bubble. A branch that is not taken continues in sequence with no bubble.

Top module: `short_branch_pc`

## Requirements
- R1: While reset is held, `fetch_addr_o` is 0 and `ex_valid_o` is 0. At the first edge after release, the slot holds the word at address 0, with `pc_o` equal to 0 and `ex_valid_o` equal to 1.
- R2: When a valid instruction does not redirect, the next cycle is valid with `pc_o` one higher and `ex_instr_o` equal to the word fetched from that address.
- R3: When `op_i` is 1 (add) and `fmt_i` is 1 (short immediate), `ofs_o` is the mapped offset: codes 1..7 give +1..+7, code 0 gives +8, and codes 8..15 give -8..-1. This holds whatever `dst_i` is. In every other case `ofs_o` is the sign-extended raw immediate.
- R4: A taken short add sets the target to `pc_o` + offset, modulo 2^AW. The base is the branch's own address, not that address plus one.
- R5: Condition codes in `cond_i` are: 0 always, 1 zero flag set, 2 zero flag clear, 3 carry set, 4 carry clear, 5..7 never.
- R6: A taken redirect raises `flush_o` in the same cycle. In the next cycle `ex_valid_o` is 0 and `fetch_addr_o` equals the target. The cycle after that is valid, with `pc_o` at the target.
- R7: A valid add or set to the PC whose condition fails keeps `flush_o` low and gives `next_pc_o` = `pc_o` + 1.
- R8: When `op_i` is 2 (set), `dst_i` equals PC_IDX (default 7) and the condition holds, the target is `set_val_i`.
- R9: A short add whose destination is not PC_IDX never redirects.
- R10: A taken short add never has a target equal to its own address.
- R11: During a bubble (`ex_valid_o` low), the decode inputs are ignored. `flush_o` stays low and the refill proceeds to the target that was already chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_addr_o | output | AW | Address being fetched this cycle |
| fetch_data_i | input | IW | Instruction word at `fetch_addr_o` |
| ex_valid_o | output | 1 | Slot holds an instruction to execute |
| ex_instr_o | output | IW | Instruction in execute |
| pc_o | output | AW | Address of the instruction in execute |
| op_i | input | 3 | Decoded opcode: 1 add, 2 set, others no redirect |
| fmt_i | input | 1 | 1 = short 4-bit immediate format |
| dst_i | input | RW | Destination register index |
| imm_i | input | 4 | Short immediate code |
| cond_i | input | 3 | Condition code |
| zf_i | input | 1 | Zero flag |
| cf_i | input | 1 | Carry flag |
| set_val_i | input | AW | Full-width value for a set to PC |
| ofs_o | output | AW | Offset operand derived from the immediate |
| flush_o | output | 1 | Redirect taken, fetched word dropped |
| next_pc_o | output | AW | Address of the next executed instruction |

## Verification
`ofs_o`, `flush_o` and `next_pc_o` are combinational and due in the same cycle as the decode inputs. The bench drives those inputs at a falling edge and samples the outputs 1 ns later, before the next rising edge. The bubble and the new fetch address appear one rising edge after a taken redirect. The target's instruction reaches execute one edge after that, so the bench checks each of these registered results at the falling edge that follows the edge producing it. For a branch that is not taken, the following instruction is due after a single edge, and the bench looks for it there with no bubble.

// File: rtl/short_branch_pc.sv
module short_branch_pc #(
  parameter int AW = 16,
  parameter int IW = 16,
  parameter int RW = 3,
  parameter int PC_IDX = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] fetch_addr_o,
  input  logic [IW-1:0] fetch_data_i,
  output logic          ex_valid_o,
  output logic [IW-1:0] ex_instr_o,
  output logic [AW-1:0] pc_o,
  input  logic [2:0]    op_i,
  input  logic          fmt_i,
  input  logic [RW-1:0] dst_i,
  input  logic [3:0]    imm_i,
  input  logic [2:0]    cond_i,
  input  logic          zf_i,
  input  logic          cf_i,
  input  logic [AW-1:0] set_val_i,
  output logic [AW-1:0] ofs_o,
  output logic          flush_o,
  output logic [AW-1:0] next_pc_o
);

  localparam logic [2:0]    OP_ADD = 3'd1;
  localparam logic [2:0]    OP_SET = 3'd2;
  localparam logic [AW-1:0] ONE    = AW'(1);

  logic [AW-1:0] fa_q, spc_q, target;
  logic [IW-1:0] slot_q;
  logic          sv_q, cond_ok, short_add, wr_pc;
  logic signed [4:0] ofs5;

  assign short_add = (op_i == OP_ADD) && fmt_i;
  assign ofs5      = (short_add && imm_i == 4'd0) ? 5'sd8 : {imm_i[3], imm_i};
  assign ofs_o     = {{(AW-5){ofs5[4]}}, ofs5};

  always_comb begin
    case (cond_i)
      3'd0:    cond_ok = 1'b1;
      3'd1:    cond_ok = zf_i;
      3'd2:    cond_ok = !zf_i;
      3'd3:    cond_ok = cf_i;
      3'd4:    cond_ok = !cf_i;
      default: cond_ok = 1'b0;
    endcase
  end

  assign wr_pc     = (dst_i == RW'(PC_IDX)) && (short_add || op_i == OP_SET);
  assign flush_o   = sv_q && wr_pc && cond_ok;
  assign target    = (op_i == OP_SET) ? set_val_i : spc_q + ofs_o;
  assign next_pc_o = flush_o ? target : spc_q + ONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fa_q   <= '0;
      spc_q  <= '0;
      slot_q <= '0;
      sv_q   <= 1'b0;
    end else if (flush_o) begin
      sv_q <= 1'b0;
      fa_q <= target;
    end else begin
      sv_q   <= 1'b1;
      slot_q <= fetch_data_i;
      spc_q  <= fa_q;
      fa_q   <= fa_q + ONE;
    end
  end

  assign fetch_addr_o = fa_q;
  assign ex_valid_o   = sv_q;
  assign ex_instr_o   = slot_q;
  assign pc_o         = spc_q;

  assert_offset_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    short_add |-> ($signed(ofs_o) != 0 && $signed(ofs_o) >= -8 && $signed(ofs_o) <= 8));

  assert_seq_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid_o && !flush_o |=> ex_valid_o && pc_o == $past(pc_o) + ONE);

  assert_bubble_after_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> !ex_valid_o && fetch_addr_o == $past(next_pc_o));

  assert_refill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_valid_o |=> ex_valid_o);

  assert_no_self_loop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o && short_add |-> next_pc_o != pc_o);

  assert_idle_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_valid_o |-> !flush_o);

endmodule

// File: tb/test_short_branch_pc.sv
`timescale 1ns/1ps
module test_short_branch_pc;
  localparam int AW = 16;
  localparam logic [15:0] KEY = 16'h5A3C;

  // {imm[14:11], cond[10:8], z[7], c[6], taken[5], offset[4:0]}
  localparam logic [14:0] VEC [32] = '{
    {4'd0, 3'd0,1'b0,1'b0,1'b1,5'd8},  {4'd0, 3'd7,1'b0,1'b0,1'b0,5'd8},
    {4'd1, 3'd1,1'b1,1'b0,1'b1,5'd1},  {4'd1, 3'd1,1'b0,1'b0,1'b0,5'd1},
    {4'd2, 3'd2,1'b0,1'b0,1'b1,5'd2},  {4'd2, 3'd2,1'b1,1'b0,1'b0,5'd2},
    {4'd3, 3'd3,1'b0,1'b1,1'b1,5'd3},  {4'd3, 3'd3,1'b1,1'b0,1'b0,5'd3},
    {4'd4, 3'd4,1'b0,1'b0,1'b1,5'd4},  {4'd4, 3'd4,1'b0,1'b1,1'b0,5'd4},
    {4'd5, 3'd0,1'b1,1'b1,1'b1,5'd5},  {4'd5, 3'd5,1'b1,1'b1,1'b0,5'd5},
    {4'd6, 3'd1,1'b1,1'b1,1'b1,5'd6},  {4'd6, 3'd1,1'b0,1'b1,1'b0,5'd6},
    {4'd7, 3'd2,1'b0,1'b1,1'b1,5'd7},  {4'd7, 3'd2,1'b1,1'b1,1'b0,5'd7},
    {4'd8, 3'd3,1'b1,1'b1,1'b1,5'd24}, {4'd8, 3'd3,1'b1,1'b0,1'b0,5'd24},
    {4'd9, 3'd4,1'b1,1'b0,1'b1,5'd25}, {4'd9, 3'd4,1'b1,1'b1,1'b0,5'd25},
    {4'd10,3'd0,1'b0,1'b1,1'b1,5'd26}, {4'd10,3'd6,1'b0,1'b1,1'b0,5'd26},
    {4'd11,3'd1,1'b1,1'b0,1'b1,5'd27}, {4'd11,3'd1,1'b0,1'b1,1'b0,5'd27},
    {4'd12,3'd2,1'b0,1'b0,1'b1,5'd28}, {4'd12,3'd2,1'b1,1'b1,1'b0,5'd28},
    {4'd13,3'd3,1'b0,1'b1,1'b1,5'd29}, {4'd13,3'd3,1'b0,1'b0,1'b0,5'd29},
    {4'd14,3'd4,1'b1,1'b0,1'b1,5'd30}, {4'd14,3'd4,1'b0,1'b1,1'b0,5'd30},
    {4'd15,3'd0,1'b0,1'b0,1'b1,5'd31}, {4'd15,3'd7,1'b1,1'b1,1'b0,5'd31}
  };

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] fetch_addr, pc, ofs, next_pc, set_val;
  logic [15:0] fetch_data, ex_instr;
  logic ex_valid, flush, fmt, zf, cf;
  logic [2:0] op, dst, cond;
  logic [3:0] imm;
  int vectors = 0, miscompares = 0;

  always #2.5 clk = ~clk;
  assign fetch_data = fetch_addr ^ KEY;

  short_branch_pc i_short_branch_pc (
    .clk(clk), .rst_n(rst_n), .fetch_addr_o(fetch_addr), .fetch_data_i(fetch_data),
    .ex_valid_o(ex_valid), .ex_instr_o(ex_instr), .pc_o(pc),
    .op_i(op), .fmt_i(fmt), .dst_i(dst), .imm_i(imm), .cond_i(cond),
    .zf_i(zf), .cf_i(cf), .set_val_i(set_val),
    .ofs_o(ofs), .flush_o(flush), .next_pc_o(next_pc));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    op = 3'd0; fmt = 0; dst = 3'd0; imm = 4'd0; cond = 3'd0; zf = 0; cf = 0; set_val = '0;
  endtask

  task automatic wait_valid();
    while (!ex_valid) @(negedge clk);
  endtask

  task automatic follow(input string req, input logic tk, input logic [AW-1:0] exp);
    @(negedge clk);
    idle();
    if (tk) begin
      chk({req, " bubble"}, ex_valid, 0);
      chk({req, " refetch"}, fetch_addr, exp);
      @(negedge clk);
    end
    chk({req, " valid"}, ex_valid, 1);
    chk({req, " pc"}, pc, exp);
    chk({req, " instr"}, ex_instr, exp ^ KEY);
  endtask

  initial begin
    #400000;
    miscompares++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [AW-1:0] p, e;
    idle();
    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1 reset valid", ex_valid, 0);
    chk("R1 reset fetch", fetch_addr, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 first valid", ex_valid, 1);
    chk("R1 first pc", pc, 0);
    chk("R1 first instr", ex_instr, KEY);

    // R3 R4 R5 R6 R7: every immediate code, taken and not taken
    for (int i = 0; i < 32; i++) begin
      logic [14:0] v;
      logic [AW-1:0] o;
      v = VEC[i];
      o = {{(AW-5){v[4]}}, v[4:0]};
      wait_valid();
      p = pc;
      op = 3'd1; fmt = 1; dst = 3'd7;
      imm = v[14:11]; cond = v[10:8]; zf = v[7]; cf = v[6];
      e = v[5] ? p + o : p + 1;
      #1;
      chk("R3 offset", ofs, o);
      chk("R5 flush", flush, v[5]);
      chk(v[5] ? "R4 target" : "R7 next", next_pc, e);
      follow(v[5] ? "R6" : "R2", v[5], e);
    end

    // R8 set taken to near top, then R4 wrap with +8
    wait_valid();
    op = 3'd2; dst = 3'd7; cond = 3'd0; set_val = 16'hFFFC;
    #1;
    chk("R8 set flush", flush, 1);
    chk("R8 set target", next_pc, 16'hFFFC);
    follow("R8", 1, 16'hFFFC);
    op = 3'd1; fmt = 1; dst = 3'd7; imm = 4'd0; cond = 3'd0;
    #1;
    chk("R4 wrap target", next_pc, 16'h0004);
    follow("R4 wrap", 1, 16'h0004);

    // R7 set with failing condition
    p = pc;
    op = 3'd2; dst = 3'd7; cond = 3'd5; set_val = 16'h0123;
    #1;
    chk("R7 set not taken", flush, 0);
    chk("R7 set next", next_pc, p + 1);
    follow("R7", 0, p + 1);

    // R9 short add to another register, R3 mapping regardless of destination
    p = pc;
    op = 3'd1; fmt = 1; dst = 3'd3; imm = 4'd0; cond = 3'd0;
    #1;
    chk("R3 non-pc offset", ofs, 16'd8);
    chk("R9 no flush", flush, 0);
    follow("R9", 0, p + 1);

    // R3 long format: raw immediate, no redirect
    p = pc;
    op = 3'd1; fmt = 0; dst = 3'd7; imm = 4'd0; cond = 3'd0;
    #1;
    chk("R3 long offset", ofs, 16'd0);
    chk("R3 long flush", flush, 0);
    follow("R3 long", 0, p + 1);

    // R10 backward -1 never targets itself
    p = pc;
    op = 3'd1; fmt = 1; dst = 3'd7; imm = 4'd15; cond = 3'd0;
    #1;
    chk("R10 target", next_pc, p - 1);
    @(negedge clk);
    // R11 decode inputs during the bubble are ignored
    op = 3'd2; dst = 3'd7; cond = 3'd0; set_val = 16'h1234;
    #1;
    chk("R11 bubble flush", flush, 0);
    chk("R11 bubble fetch", fetch_addr, p - 1);
    @(negedge clk);
    idle();
    chk("R11 refill pc", pc, p - 1);
    chk("R11 refill valid", ex_valid, 1);

    // R1 reset in mid-run
    rst_n = 0;
    @(negedge clk);
    chk("R1 rerst valid", ex_valid, 0);
    chk("R1 rerst fetch", fetch_addr, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rerst pc", pc, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule